// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that retires one instruction on every enabled clock edge. It covers five register-to-register arithmetic and logic operations, a word load, a word store and a conditional branch on equality. The core holds its own program counter, a register file, the main ALU, a sign extender with a branch-target adder, an instruction decoder, and two separate word-addressed arrays: one for instructions and one for data. Because the two arrays are separate, the core can fetch an instruction and access data in the same cycle.

The host holds `run` low while it fills either array through a word-wide load port. Raising `run` lets the core step one instruction per clock. Two read-only peek ports show any register and any data word, so the host can see the architectural state without disturbing it. `rst_n` is asserted asynchronously and released through a two-stage synchronizer. The internal reset therefore ends two rising edges after `rst_n` goes high.

Top module: `sc_core`

## Requirements
- R1: While reset is active, and after it is released, the PC reads 0 and every register reads 0 until an instruction changes it.
- R2: While `run` is low, the PC, the registers and the data array keep their values. A load-port write (`ld_en`=1) stores `ld_data` at word `ld_addr` of the data array if `ld_dmem`=1, or of the instruction array if `ld_dmem`=0.
- R3: Instruction fields are opcode [31:26], rs [25:21], rt [20:16], rd [15:11], funct [5:0] and offset [15:0]. When opcode is 0, the result is written to rd: funct 0x20 gives rs+rt, 0x22 gives rs-rt, 0x24 gives rs AND rt, and 0x25 gives rs OR rt.
- R4: Opcode 0 with funct 0x2A writes 1 to rd when rs is less than rt as signed 32-bit numbers, and writes 0 otherwise.
- R5: Opcode 0x23 (load) writes rt with the data word at index bits [MEM_AW+1:2] of rs + sign-extended offset.
- R6: Opcode 0x2B (store) writes rt into the data word at the same computed index and writes no register.
- R7: Opcode 0x04 (branch) sets the next PC to PC+4+(sign-extended offset << 2) when rs equals rt, and to PC+4 otherwise. It writes no register and no memory.
- R8: Register 0 always reads 0, and writes to it are discarded.
- R9: Any other opcode, or opcode 0 with any other funct, writes neither a register nor memory. Every instruction except a taken branch advances the PC by 4.
- R10: The instruction is fetched from instruction word PC[MEM_AW+1:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the core |
| run | input | 1 | Clock enable: executes one instruction per edge when high |
| ld_en | input | 1 | Load-port write strobe |
| ld_dmem | input | 1 | Load-port target: 1 selects the data array, 0 selects the instruction array |
| ld_addr | input | MEM_AW | Load-port word index |
| ld_data | input | 32 | Load-port write data |
| peek_reg_addr | input | 5 | Register peek index |
| peek_reg_data | output | 32 | Register peek value |
| peek_mem_addr | input | MEM_AW | Data-array peek word index |
| peek_mem_data | output | 32 | Data-array peek value |
| pc | output | 32 | Current program counter |

## Verification
The bench uses the default MEM_AW of 6, so each array has 64 words. With arrays this small, random base registers and offsets fold into the same few data words, and loads often read back words that earlier random stores wrote. Random branch offsets move the 32-bit PC far from zero. Because the instruction index is only six bits, such jumps still land in the loaded instruction array, which exercises the PC-bit truncation of R10 on every step.

// File: rtl/sc_pkg.sv
package sc_pkg;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic    dst_rd;     // write register comes from rd, not rt
    logic    reg_we;
    logic    src_imm;    // ALU operand B is the sign-extended offset
    alu_op_e alu_op;
    logic    mem_we;
    logic    mem_re;
    logic    wb_mem;     // write-back comes from the data array
    logic    is_branch;
  } ctrl_t;

  localparam logic [5:0] OPC_RTYPE = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;
  localparam logic [5:0] OPC_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '{dst_rd: 1'b0, reg_we: 1'b0, src_imm: 1'b0, alu_op: ALU_ADD,
             mem_we: 1'b0, mem_re: 1'b0, wb_mem: 1'b0, is_branch: 1'b0};
    unique case (opcode)
      OPC_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        ctrl.reg_we = 1'b1;
        unique case (funct)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OPC_LOAD: begin
        ctrl.reg_we  = 1'b1;
        ctrl.src_imm = 1'b1;
        ctrl.mem_re  = 1'b1;
        ctrl.wb_mem  = 1'b1;
      end
      OPC_STORE: begin
        ctrl.src_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.alu_op    = ALU_SUB;
        ctrl.is_branch = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);

  logic [W-1:0] diff;
  assign diff = a - b;

  always_comb begin
    unique case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = diff;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter  int W    = 32,
  parameter  int NREG = 32,
  localparam int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  input  logic [AW-1:0] ra_c,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b,
  output logic [W-1:0]  rd_c
);

  logic [W-1:0] q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign q[i] = '0;
    end else begin : g_flop
      logic [W-1:0] r;
      logic         hit;
      assign hit = we && (waddr == AW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   r <= '0;
        else if (hit) r <= wdata;
      end
      assign q[i] = r;
    end
  end

  assign rd_a = q[ra_a];
  assign rd_b = q[ra_b];
  assign rd_c = q[ra_c];

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int W      = 32,
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ld_en,
  input  logic              ld_dmem,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [W-1:0]      ld_data,
  input  logic [4:0]        peek_reg_addr,
  output logic [W-1:0]      peek_reg_data,
  input  logic [MEM_AW-1:0] peek_mem_addr,
  output logic [W-1:0]      peek_mem_data,
  output logic [W-1:0]      pc
);

  localparam int DEPTH = 2 ** MEM_AW;

  // reset synchronizer
  logic [1:0] rst_sync;
  logic       core_rst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  // arrays
  logic [W-1:0] imem [DEPTH];
  logic [W-1:0] dmem [DEPTH];

  logic [W-1:0] instr;
  assign instr = imem[pc[MEM_AW+1:2]];

  logic [5:0] opcode, funct;
  logic [4:0] rs, rt, rd;
  logic [15:0] offs;
  assign opcode = instr[31:26];
  assign rs     = instr[25:21];
  assign rt     = instr[20:16];
  assign rd     = instr[15:11];
  assign funct  = instr[5:0];
  assign offs   = instr[15:0];

  ctrl_t ctrl;
  sc_decode i_dec (.opcode(opcode), .funct(funct), .ctrl(ctrl));

  logic [W-1:0] rs_val, rt_val, wb_data, imm_ext, alu_b, alu_y;
  logic         alu_zero, rf_we;
  logic [4:0]   rf_waddr;

  assign imm_ext = {{(W-16){offs[15]}}, offs};
  assign alu_b   = ctrl.src_imm ? imm_ext : rt_val;

  sc_alu #(.W(W)) i_alu (.a(rs_val), .b(alu_b), .op(ctrl.alu_op), .y(alu_y), .zero(alu_zero));

  logic [MEM_AW-1:0] dm_idx;
  logic [W-1:0]      dm_rdata;
  logic              dm_we;
  assign dm_idx   = alu_y[MEM_AW+1:2];
  assign dm_rdata = ctrl.mem_re ? dmem[dm_idx] : '0;
  assign dm_we    = run && ctrl.mem_we;

  assign rf_we    = run && ctrl.reg_we;
  assign rf_waddr = ctrl.dst_rd ? rd : rt;
  assign wb_data  = ctrl.wb_mem ? dm_rdata : alu_y;

  sc_regfile #(.W(W), .NREG(32)) i_rf (
    .clk(clk), .rst_n(core_rst_n), .we(rf_we), .waddr(rf_waddr), .wdata(wb_data),
    .ra_a(rs), .ra_b(rt), .ra_c(peek_reg_addr),
    .rd_a(rs_val), .rd_b(rt_val), .rd_c(peek_reg_data)
  );

  // next PC
  logic [W-1:0] pc_plus4, br_tgt, pc_nxt;
  assign pc_plus4 = pc + W'(4);
  assign br_tgt   = pc_plus4 + {imm_ext[W-3:0], 2'b00};
  assign pc_nxt   = (ctrl.is_branch && alu_zero) ? br_tgt : pc_plus4;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) pc <= '0;
    else if (run)    pc <= pc_nxt;
  end

  // array writes (no reset on storage)
  always_ff @(posedge clk) begin
    if (ld_en && !ld_dmem) imem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (dm_we)                dmem[dm_idx]  <= rt_val;
    else if (ld_en && ld_dmem) dmem[ld_addr] <= ld_data;
  end

  assign peek_mem_data = dmem[peek_mem_addr];

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         core_rst_n,
  input logic         run,
  input logic [W-1:0] pc,
  input logic [5:0]   opcode,
  input logic [W-1:0] rs_val,
  input logic [W-1:0] rt_val,
  input logic [W-1:0] imm_ext,
  input logic         dm_we,
  input logic         rf_we,
  input logic [4:0]   peek_reg_addr,
  input logic [W-1:0] peek_reg_data
);

  p_pc_reset_r1: assert property (@(posedge clk) $rose(core_rst_n) |-> pc == '0);

  p_hold_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    !run |=> $stable(pc));

  p_seq_r9: assert property (@(posedge clk) disable iff (!core_rst_n)
    (run && opcode != OPC_BEQ) |=> pc == $past(pc) + W'(4));

  p_taken_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (run && opcode == OPC_BEQ && rs_val == rt_val)
      |=> pc == $past(pc) + W'(4) + ($past(imm_ext) << 2));

  p_store_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    dm_we |-> (run && opcode == OPC_STORE));

  p_store_noreg_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (opcode == OPC_STORE || opcode == OPC_BEQ) |-> !rf_we);

  p_zero_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    peek_reg_addr == 5'd0 |-> peek_reg_data == '0);

endmodule

bind sc_core sc_core_chk #(.W(W)) i_chk (
  .clk(clk), .core_rst_n(core_rst_n), .run(run), .pc(pc), .opcode(opcode),
  .rs_val(rs_val), .rt_val(rt_val), .imm_ext(imm_ext), .dm_we(dm_we),
  .rf_we(rf_we), .peek_reg_addr(peek_reg_addr), .peek_reg_data(peek_reg_data)
);

// File: tb/test_sc_core.sv
module test_sc_core;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DEPTH = 2 ** AW;

  logic          clk = 1'b0;
  logic          rst_n, run, ld_en, ld_dmem;
  logic [AW-1:0] ld_addr, peek_mem_addr;
  logic [31:0]   ld_data, peek_reg_data, peek_mem_data, pc;
  logic [4:0]    peek_reg_addr;

  sc_core #(.W(32), .MEM_AW(AW)) i_sc_core (
    .clk(clk), .rst_n(rst_n), .run(run), .ld_en(ld_en), .ld_dmem(ld_dmem),
    .ld_addr(ld_addr), .ld_data(ld_data), .peek_reg_addr(peek_reg_addr),
    .peek_reg_data(peek_reg_data), .peek_mem_addr(peek_mem_addr),
    .peek_mem_data(peek_mem_data), .pc(pc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_reg [32];
  logic [31:0] m_mem [DEPTH];
  logic [31:0] m_pc;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] s,
                                        input logic [4:0] t, input logic [4:0] d);
    return {6'h00, s, t, d, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] s,
                                        input logic [4:0] t, input logic [15:0] im);
    return {op, s, t, im};
  endfunction

  function automatic logic [31:0] sext(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic load_word(input bit to_dmem, input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_dmem = to_dmem; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic peek_reg(input logic [4:0] a, output logic [31:0] v);
    peek_reg_addr = a; #1; v = peek_reg_data;
  endtask

  task automatic peek_mem(input logic [AW-1:0] a, output logic [31:0] v);
    peek_mem_addr = a; #1; v = peek_mem_data;
  endtask

  // executes one instruction in the model and in the core, then compares
  task automatic step(input logic [31:0] ins, input string tag);
    logic [5:0] op, fn;
    logic [4:0] s, t, d, wr;
    logic [31:0] a, b, res, ea, nxt, v;
    bit we_reg, we_mem;
    op = ins[31:26]; s = ins[25:21]; t = ins[20:16]; d = ins[15:11]; fn = ins[5:0];
    a = m_reg[s]; b = m_reg[t];
    we_reg = 0; we_mem = 0; wr = 0; res = 0;
    ea  = a + sext(ins[15:0]);
    nxt = m_pc + 32'd4;
    if (op == 6'h00) begin
      we_reg = 1; wr = d;
      case (fn)
        6'h20: res = a + b;
        6'h22: res = a - b;
        6'h24: res = a & b;
        6'h25: res = a | b;
        6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        default: we_reg = 0;
      endcase
    end else if (op == 6'h23) begin
      we_reg = 1; wr = t; res = m_mem[ea[AW+1:2]];
    end else if (op == 6'h2B) begin
      we_mem = 1;
    end else if (op == 6'h04) begin
      if (a == b) nxt = m_pc + 32'd4 + (sext(ins[15:0]) << 2);
    end
    load_word(1'b0, m_pc[AW+1:2], ins);
    @(negedge clk); run = 1'b1;
    @(negedge clk); run = 1'b0;
    if (we_reg && wr != 0) m_reg[wr] = res;
    if (we_mem) m_mem[ea[AW+1:2]] = b;
    m_pc = nxt;
    check({tag, " pc"}, pc, m_pc);
    if (we_mem) begin
      peek_mem(ea[AW+1:2], v);
      check({tag, " mem"}, v, m_mem[ea[AW+1:2]]);
    end else begin
      peek_reg(we_reg ? wr : t, v);
      check({tag, " reg"}, v, m_reg[we_reg ? wr : t]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] pc_hold;
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; run = 1'b0; ld_en = 1'b0; ld_dmem = 1'b0;
    ld_addr = '0; ld_data = '0; peek_reg_addr = '0; peek_mem_addr = '0;
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    m_pc = '0;
    repeat (3) @(negedge clk);
    check("R1 pc in reset", pc, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 pc after reset", pc, 32'd0);
    peek_reg(5'd7, v);  check("R1 reg7 after reset", v, 32'd0);
    peek_reg(5'd31, v); check("R1 reg31 after reset", v, 32'd0);

    // R2: fill data array while halted, PC stays put
    for (int i = 0; i < DEPTH; i++) begin
      m_mem[i] = $urandom;
      load_word(1'b1, AW'(i), m_mem[i]);
    end
    check("R2 pc held while halted", pc, 32'd0);
    peek_mem(AW'(5), v);  check("R2 load port dmem word 5", v, m_mem[5]);
    peek_mem(AW'(63), v); check("R2 load port dmem word 63", v, m_mem[63]);

    // R5: load every register from the data array
    for (int r = 1; r < 32; r++)
      step(enc_i(6'h23, 5'd0, 5'(r), 16'(r * 4)), "R5 load");

    // R2: halt holds state across cycles
    pc_hold = pc;
    repeat (4) @(negedge clk);
    check("R2 pc stable with run low", pc, pc_hold);
    peek_reg(5'd9, v); check("R2 reg stable with run low", v, m_reg[9]);

    // directed corner cases
    m_reg[0] = '0;
    step(enc_r(6'h20, 5'd3, 5'd4, 5'd0), "R8 write to reg0");
    peek_reg(5'd0, v); check("R8 reg0 reads zero", v, 32'd0);
    step(enc_i(6'h23, 5'd0, 5'd10, 16'd0), "R5 load reg10");
    step(enc_i(6'h23, 5'd0, 5'd11, 16'd0), "R5 load reg11 same word");
    step(enc_i(6'h04, 5'd10, 5'd11, 16'hFFF0), "R7 taken backward");
    step(enc_i(6'h04, 5'd10, 5'd12, 16'h0007), "R7 not taken");
    step(enc_r(6'h2A, 5'd0, 5'd0, 5'd13), "R4 slt equal");
    step(enc_r(6'h22, 5'd0, 5'd10, 5'd14), "R3 sub negate");
    step(enc_r(6'h2A, 5'd14, 5'd10, 5'd15), "R4 slt signed");
    step(enc_r(6'h2A, 5'd10, 5'd14, 5'd16), "R4 slt signed reverse");
    step(enc_i(6'h2B, 5'd0, 5'd14, 16'h0008), "R6 store word 2");
    step(enc_i(6'h23, 5'd0, 5'd17, 16'h0008), "R5 load back stored");
    step(enc_i(6'h3F, 5'd1, 5'd2, 16'h1234), "R9 unknown opcode");
    step(enc_r(6'h00, 5'd1, 5'd2, 5'd3), "R9 unknown funct");
    peek_reg(5'd3, v); check("R9 rd untouched", v, m_reg[3]);

    // constrained random mix
    for (int n = 0; n < 1500; n++) begin
      logic [4:0] s, t, d;
      logic [15:0] im;
      int k;
      s = 5'($urandom); t = 5'($urandom); d = 5'($urandom);
      im = 16'($urandom);
      k = $urandom_range(0, 9);
      case (k)
        0: step(enc_r(6'h20, s, t, d), "R3 add");
        1: step(enc_r(6'h22, s, t, d), "R3 sub");
        2: step(enc_r(6'h24, s, t, d), "R3 and");
        3: step(enc_r(6'h25, s, t, d), "R3 or");
        4: step(enc_r(6'h2A, s, t, d), "R4 slt");
        5: step(enc_i(6'h23, s, t, im), "R5 load");
        6: step(enc_i(6'h2B, s, t, im), "R6 store");
        7: step(enc_i(6'h04, s, ($urandom_range(0, 2) == 0) ? t : s, im), "R7 branch");
        8: step(enc_i(6'($urandom_range(1, 3)), s, t, im), "R9 other opcode");
        default: step(enc_r(6'h20, s, t, d), "R10 fetch add");
      endcase
    end
    for (int r = 0; r < 32; r++) begin
      peek_reg(5'(r), v); check("R3 final register file", v, m_reg[r]);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule